// File: doc/BRIEF.md
# Downward-Growing Memory Stack Pointer with Bound Registers

This block manages a stack kept in a region of word-addressed memory. The stack grows toward lower addresses. The block holds the stack pointer and turns push and pop requests into address, write and read strobes on a simple synchronous memory port. A push moves the pointer down one word and then stores the push data at the new pointer. A pop reads the word the pointer addresses and then moves the pointer up. Once the synchronous read data returns, the block hands it out with a one-cycle valid pulse.

Two bound registers guard the stack. The floor is the lowest usable address, and pushes stop there. The ceiling is the pointer value of an empty stack, and pops stop there. A push with the pointer at the floor, or a pop with the pointer at the ceiling, is refused. The pointer stays where it is, no memory access is made, and a one-cycle overflow or underflow flag is raised. After reset the pointer and the ceiling are 4001 and the floor is 3000. The first push therefore lands at 4000 and the last at 3000. A small configuration port can reload the pointer base and both bounds while the block is idle.

Top module: `mstk_ctrl`

## Requirements
- R1: After reset: pointer 4001, floor 3000, ceiling 4001, `empty` 1, `full` 0, and `mem_we`, `mem_re`, `busy`, `pop_valid`, `overflow`, `underflow` all 0.
- R2: An accepted push drives `mem_we` for exactly the one cycle after the request edge. In that cycle `mem_addr` equals the pointer minus one, `mem_wdata` equals `push_data`, and `sp` already shows the decremented value.
- R3: An accepted pop drives `mem_re` for the one cycle after the request edge. In that cycle `mem_addr` equals the old pointer and `sp` equals the old pointer plus one. Two cycles after the `mem_re` cycle, `pop_valid` is 1 for one cycle and `pop_data` carries the memory word.
- R4: A push while `sp` equals the floor makes no write and leaves `sp` unchanged. It raises `overflow` for one cycle.
- R5: A pop while `sp` equals the ceiling makes no read and leaves `sp` unchanged. It raises `underflow` for one cycle.
- R6: `full` is 1 exactly when `sp` equals the floor, and `empty` is 1 exactly when `sp` equals the ceiling.
- R7: Popped words come back in the reverse of the order in which they were pushed.
- R8: While a pop is in flight (`busy` = 1, the two cycles after acceptance), push, pop and configuration writes are ignored.
- R9: A configuration write while idle acts by `cfg_sel`. Code 0 sets the pointer to `cfg_wdata`. Code 1 sets the floor. Code 2 sets the ceiling. Code 3 has no effect.
- R10: When push and pop are requested in the same idle cycle, the push is performed and the pop is dropped.
- R11: An idle cycle that carries a configuration write performs only that write. Any push or pop request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | DW | Word to push |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 base/pointer, 1 floor, 2 ceiling, 3 none |
| cfg_wdata | input | AW | Configuration value |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_re` |
| pop_data | output | DW | Popped word |
| pop_valid | output | 1 | One-cycle pulse when `pop_data` is new |
| busy | output | 1 | Pop in flight |
| full | output | 1 | Pointer at floor |
| empty | output | 1 | Pointer at ceiling |
| overflow | output | 1 | One-cycle pulse on a refused push |
| underflow | output | 1 | One-cycle pulse on a refused pop |
| sp | output | AW | Current stack pointer |

## Verification
The hardest case to reach from the ports is a request or configuration write that arrives while a pop is still waiting for its read data. The bench starts a pop and, in the very next cycle, raises a push together with a base reload. It then checks that no write strobe appears, that the pointer does not move, and that the popped word still arrives intact. The bounds are also hard to reach under the reset values, because the stack holds 1001 words. The bench fills and drains that stack once in full. It then shrinks the bounds to a four-word window and runs every six-operation push/pop sequence against an arithmetic model.

// File: rtl/mstk_pkg.sv
package mstk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } eng_state_e;

    localparam logic [1:0] CFG_BASE  = 2'd0;
    localparam logic [1:0] CFG_FLOOR = 2'd1;
    localparam logic [1:0] CFG_CEIL  = 2'd2;

endpackage

// File: rtl/mstk_limits.sv
module mstk_limits
    import mstk_pkg::*;
#(
    parameter int AW         = 12,
    parameter int INIT_PTR   = 4001,
    parameter int FLOOR_INIT = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] sp,
    output logic          at_floor,
    output logic          at_ceil
);

    localparam logic [AW-1:0] FLOOR_RST = AW'(FLOOR_INIT);
    localparam logic [AW-1:0] CEIL_RST  = AW'(INIT_PTR);

    typedef struct packed {
        logic [AW-1:0] floor;
        logic [AW-1:0] ceil;
    } lim_t;

    lim_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (wr_en) begin
            case (wr_sel)
                CFG_FLOOR: lim_d.floor = wr_data;
                CFG_CEIL:  lim_d.ceil  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q.floor <= FLOOR_RST;
            lim_q.ceil  <= CEIL_RST;
        end else begin
            lim_q <= lim_d;
        end
    end

    assign at_floor = (sp == lim_q.floor);
    assign at_ceil  = (sp == lim_q.ceil);

    // R9
    floor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CFG_FLOOR) |=> (lim_q.floor == $past(wr_data)));

    // R9
    limits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == CFG_BASE || wr_sel == 2'd3) |=> $stable(lim_q));

endmodule

// File: rtl/mstk_engine.sv
module mstk_engine
    import mstk_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 16,
    parameter int INIT_PTR = 4001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [DW-1:0] push_data,
    input  logic          cfg_take,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          at_floor,
    input  logic          at_ceil,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic          busy,
    output logic          overflow,
    output logic          underflow,
    output logic [AW-1:0] sp
);

    localparam logic [AW-1:0] SP_RST = AW'(INIT_PTR);
    localparam logic [AW-1:0] ONE    = AW'(1);

    typedef struct packed {
        eng_state_e    state;
        logic [AW-1:0] sp;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          we;
        logic          re;
        logic          ovf;
        logic          unf;
        logic [DW-1:0] pdata;
        logic          pvalid;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.we     = 1'b0;
        st_d.re     = 1'b0;
        st_d.ovf    = 1'b0;
        st_d.unf    = 1'b0;
        st_d.pvalid = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (cfg_take) begin
                    if (cfg_sel == CFG_BASE) begin
                        st_d.sp = cfg_wdata;
                    end
                end else if (push_req) begin
                    if (at_floor) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        st_d.sp    = st_q.sp - ONE;
                        st_d.addr  = st_q.sp - ONE;
                        st_d.wdata = push_data;
                        st_d.we    = 1'b1;
                    end
                end else if (pop_req) begin
                    if (at_ceil) begin
                        st_d.unf = 1'b1;
                    end else begin
                        st_d.addr  = st_q.sp;
                        st_d.sp    = st_q.sp + ONE;
                        st_d.re    = 1'b1;
                        st_d.state = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                st_d.state = ST_DATA;
            end
            ST_DATA: begin
                st_d.pdata  = mem_rdata;
                st_d.pvalid = 1'b1;
                st_d.state  = ST_IDLE;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= ST_IDLE;
            st_q.sp     <= SP_RST;
            st_q.addr   <= '0;
            st_q.wdata  <= '0;
            st_q.we     <= 1'b0;
            st_q.re     <= 1'b0;
            st_q.ovf    <= 1'b0;
            st_q.unf    <= 1'b0;
            st_q.pdata  <= '0;
            st_q.pvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.addr;
    assign mem_we    = st_q.we;
    assign mem_re    = st_q.re;
    assign mem_wdata = st_q.wdata;
    assign pop_data  = st_q.pdata;
    assign pop_valid = st_q.pvalid;
    assign busy      = (st_q.state != ST_IDLE);
    assign overflow  = st_q.ovf;
    assign underflow = st_q.unf;
    assign sp        = st_q.sp;

    // R2
    push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> ((st_q.addr == st_q.sp) && (st_q.sp == $past(st_q.sp) - ONE)));

    // R3
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.re |-> ##2 st_q.pvalid);

    // R4
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && !cfg_take && push_req && at_floor)
            |=> (st_q.ovf && !st_q.we && $stable(st_q.sp)));

    // R5
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE && !cfg_take && !push_req && pop_req && at_ceil)
            |=> (st_q.unf && !st_q.re && $stable(st_q.sp)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != ST_IDLE) |=> ($stable(st_q.sp) && !st_q.we && !st_q.re));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.we, st_q.re, st_q.ovf, st_q.unf}));

endmodule

// File: rtl/mstk_ctrl.sv
module mstk_ctrl
    import mstk_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 16,
    parameter int INIT_PTR   = 4001,
    parameter int FLOOR_INIT = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [DW-1:0] push_data,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic          busy,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic          underflow,
    output logic [AW-1:0] sp
);

    logic          cfg_take;
    logic          at_floor;
    logic          at_ceil;
    logic          busy_w;
    logic [AW-1:0] sp_w;

    assign cfg_take = cfg_we && !busy_w;

    mstk_limits #(
        .AW         (AW),
        .INIT_PTR   (INIT_PTR),
        .FLOOR_INIT (FLOOR_INIT)
    ) u_limits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_take),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .sp       (sp_w),
        .at_floor (at_floor),
        .at_ceil  (at_ceil)
    );

    mstk_engine #(
        .AW       (AW),
        .DW       (DW),
        .INIT_PTR (INIT_PTR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .cfg_take  (cfg_take),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .at_floor  (at_floor),
        .at_ceil   (at_ceil),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .busy      (busy_w),
        .overflow  (overflow),
        .underflow (underflow),
        .sp        (sp_w)
    );

    assign busy  = busy_w;
    assign sp    = sp_w;
    assign full  = at_floor;
    assign empty = at_ceil;

    // R8
    cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && cfg_we) |=> $stable(sp_w));

endmodule

// File: tb/mstk_ctrl_bench.sv
module mstk_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] pop_data;
    logic          pop_valid;
    logic          busy;
    logic          full;
    logic          empty;
    logic          overflow;
    logic          underflow;
    logic [AW-1:0] sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    mstk_ctrl u_mstk_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .busy      (busy),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .underflow (underflow),
        .sp        (sp)
    );

    logic [DW-1:0] ram [0:(1<<AW)-1];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    int msp;
    int mfloor;
    int mceil;
    logic [DW-1:0] shadow [0:(1<<AW)-1];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic check_levels();
        chk("R6 full level", {31'd0, full}, {31'd0, msp == mfloor});
        chk("R6 empty level", {31'd0, empty}, {31'd0, msp == mceil});
    endtask

    task automatic do_cfg(input logic [1:0] s, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = AW'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        case (s)
            2'd0: msp = v;
            2'd1: mfloor = v;
            2'd2: mceil = v;
            default: ;
        endcase
        chk("R9 pointer after config", {20'd0, sp}, msp);
        check_levels();
    endtask

    task automatic do_push(input logic [DW-1:0] v);
        @(negedge clk);
        push_req = 1'b1; push_data = v;
        @(negedge clk);
        push_req = 1'b0;
        if (msp == mfloor) begin
            chk("R4 overflow pulse", {31'd0, overflow}, 32'd1);
            chk("R4 no write", {31'd0, mem_we}, 32'd0);
            chk("R4 pointer held", {20'd0, sp}, msp);
        end else begin
            msp = msp - 1;
            shadow[msp] = v;
            chk("R2 write strobe", {31'd0, mem_we}, 32'd1);
            chk("R2 write address", {20'd0, mem_addr}, msp);
            chk("R2 write data", {16'd0, mem_wdata}, {16'd0, v});
            chk("R2 pointer", {20'd0, sp}, msp);
        end
        check_levels();
    endtask

    task automatic do_pop();
        logic [DW-1:0] e;
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        if (msp == mceil) begin
            chk("R5 underflow pulse", {31'd0, underflow}, 32'd1);
            chk("R5 no read", {31'd0, mem_re}, 32'd0);
            chk("R5 pointer held", {20'd0, sp}, msp);
            check_levels();
        end else begin
            chk("R3 read strobe", {31'd0, mem_re}, 32'd1);
            chk("R3 read address", {20'd0, mem_addr}, msp);
            e = shadow[msp];
            msp = msp + 1;
            chk("R3 pointer", {20'd0, sp}, msp);
            chk("R8 busy", {31'd0, busy}, 32'd1);
            @(negedge clk);
            chk("R3 no early valid", {31'd0, pop_valid}, 32'd0);
            @(negedge clk);
            chk("R3 valid pulse", {31'd0, pop_valid}, 32'd1);
            chk("R7 popped word", {16'd0, pop_data}, {16'd0, e});
            chk("R8 busy released", {31'd0, busy}, 32'd0);
            check_levels();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        msp = 4001; mfloor = 3000; mceil = 4001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pointer", {20'd0, sp}, 32'd4001);
        chk("R1 empty", {31'd0, empty}, 32'd1);
        chk("R1 full", {31'd0, full}, 32'd0);
        chk("R1 strobes", {28'd0, mem_we, mem_re, busy, pop_valid}, 32'd0);
        chk("R1 flags", {30'd0, overflow, underflow}, 32'd0);

        // Full depth under reset bounds: 4000 first, 3000 last, then refusal
        do_pop();
        for (int i = 0; i < 1001; i++) do_push(DW'(i * 7 + 3));
        chk("R2 last location", {20'd0, sp}, 32'd3000);
        do_push(16'hBEEF);
        for (int i = 0; i < 1001; i++) do_pop();
        do_pop();

        // Shrink the window to four words
        do_cfg(2'd0, 20);
        do_cfg(2'd1, 16);
        do_cfg(2'd2, 20);
        do_cfg(2'd3, 5);
        do_push(16'h1111);
        do_cfg(2'd3, 17);
        chk("R9 code 3 no effect", {31'd0, full}, 32'd0);
        do_pop();

        // Every six-operation push/pop pattern
        for (int p = 0; p < 64; p++) begin
            for (int b = 0; b < 6; b++) begin
                if (p[b]) do_push(DW'(p * 16 + b));
                else do_pop();
            end
        end
        while (msp != mceil) do_pop();

        // R10: simultaneous push and pop
        @(negedge clk);
        push_req = 1'b1; pop_req = 1'b1; push_data = 16'hA5A5;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        msp = msp - 1; shadow[msp] = 16'hA5A5;
        chk("R10 push taken", {31'd0, mem_we}, 32'd1);
        chk("R10 pop dropped", {31'd0, mem_re}, 32'd0);
        chk("R10 pointer", {20'd0, sp}, msp);

        // R11: config write with a push in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = AW'(msp); push_req = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; push_req = 1'b0;
        mfloor = msp;
        chk("R11 push dropped", {31'd0, mem_we}, 32'd0);
        chk("R11 floor applied", {31'd0, full}, 32'd1);
        chk("R11 pointer held", {20'd0, sp}, msp);
        do_push(16'h0BAD);
        do_cfg(2'd1, 16);

        // R8: push and base reload arriving while the pop waits for data
        do_push(16'h7777);
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        push_req = 1'b1; push_data = 16'hDEAD;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 12'd5;
        @(negedge clk);
        push_req = 1'b0; cfg_we = 1'b0;
        chk("R8 push ignored", {31'd0, mem_we}, 32'd0);
        chk("R8 pointer held", {20'd0, sp}, msp + 1);
        @(negedge clk);
        chk("R8 pop completes", {31'd0, pop_valid}, 32'd1);
        chk("R8 pop word", {16'd0, pop_data}, 32'h7777);
        msp = msp + 1;
        chk("R8 base reload ignored", {20'd0, sp}, msp);
        do_pop();
        chk("R7 older word", {16'd0, pop_data}, 32'hA5A5);

        finish_run();
    end

endmodule